// File: doc/BRIEF.md
# Level-Sensitive Interrupt Pin Router

This block steers eight level-sensitive interrupt pins onto a sixteen-line legacy interrupt vector. Each pin has its own routing register. The register holds a disable flag and a four-bit line number, and the pin drives the selected line whenever at least one of its sources is active. Attached devices do not hand over a raw level. Each device sends one-cycle raise and lower events on its pin, and the block keeps a count of outstanding sources for every pin.

Software reprograms a pin through a small register port that selects the pin by index. Because the output is recomputed from the stored register and the count every cycle, a reroute while the pin is active moves the level off the old line and onto the new one in the same cycle. Line numbers outside a fixed legal set leave the pin silent, just as the disable flag does.

Top module: `irq_steer`

## Requirements
- R1: While reset is asserted, every routing register returns to 0x80 (disabled, line 0), every source count returns to zero, `irq_out` is all zero and `ovf_err` is low.
- R2: A write with `cfg_we` high stores `cfg_wdata & 0x8F` into the register of pin `cfg_sel` (0 selects the first pin). Bit 7 is the disable flag and bits 3:0 are the line number. `cfg_rdata` always shows the stored value of the selected pin.
- R3: Line k of `irq_out` is high in a cycle exactly when some pin has a nonzero count, a clear bit 7 and line number k, and bit k of the legal mask 0xDEF8 is set.
- R4: A pin programmed with a reserved line number (0, 1, 2, 8 or 13) drives nothing, just as a disabled pin drives nothing.
- R5: A raise event adds one to the pin's count and a lower event subtracts one. The routed line rises with the first outstanding source and falls only when the last one is withdrawn.
- R6: A write that changes an active pin's register drops the old line (if it was valid) and raises the new line (if it is valid). Both take effect in the cycle after the write.
- R7: A write whose masked value equals the stored value leaves `irq_out` and the register unchanged.
- R8: When several pins route to the same line, that line is the OR of them and stays high while any of them drives it.
- R9: Raise and lower events in the same cycle as a write to the same pin are applied first. The output in the following cycle reflects both the new count and the new register.
- R10: A lower event that would take a count below zero is ignored. The count stays at zero and `ovf_err` is high for exactly the following cycle.
- R11: A count at its maximum (15 by default) ignores further raise events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Pin index for read and write |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Stored register of the selected pin |
| src_up | input | 8 | Per-pin raise event |
| src_down | input | 8 | Per-pin lower event |
| irq_out | output | 16 | Interrupt line vector |
| ovf_err | output | 1 | One-cycle flag for a lower event at count zero |

## Verification
Every one of the 256 write values is applied to each pin while that pin is active. This separates the disable flag, the reserved line numbers and the masked-off bits from each other, and it compares each reroute against its neighbour value. Directed sequences stack and drain sources on one pin, on shared lines and at the count ceiling, which shows edge-only behaviour apart from plain level following. A pseudo-random phase then overlaps events on several pins with writes in the same cycle, so that the ordering of events against writes is exercised.

// File: rtl/irq_steer_pkg.sv
// Shared constants of the interrupt pin router.
// Assumes a four-bit line field, which gives sixteen output lines.
package irq_steer_pkg;
    localparam int          CFG_W    = 8;
    localparam int          NUM_W    = 4;
    localparam int          LINES    = 1 << NUM_W;
    localparam int          OFF_BIT  = 7;
    localparam logic [7:0]  KEEP     = 8'h8F;
    localparam logic [7:0]  CFG_RST  = 8'h80;
endpackage

// File: rtl/irq_slot.sv
// One routing slot: the pin's register, its source counter and its line drive.
// Assumes raise/lower events are single-cycle pulses; the write and the events
// of one cycle are folded together so that the events come first.
module irq_slot
    import irq_steer_pkg::*;
#(
    parameter int           CNT_W  = 4,
    parameter logic [15:0]  LEGAL  = 16'hDEF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             ev_up,
    input  logic             ev_down,
    output logic [CFG_W-1:0] cfg_q,
    output logic [LINES-1:0] drive,
    output logic             under_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_plus, cnt_d;
    logic             under_c, valid;

    // Fold the raise event (saturating), then the lower event (floored at zero).
    always_comb begin
        cnt_plus = (ev_up && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
        under_c  = ev_down && (cnt_plus == '0);
        cnt_d    = (ev_down && !under_c) ? cnt_plus - 1'b1 : cnt_plus;
    end

    // Hold the count, the masked register and the underflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cfg_q   <= CFG_RST;
            under_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            under_q <= under_c;
            if (wr_en) cfg_q <= wr_data & KEEP;
        end
    end

    // Decode the line this slot drives, if any.
    always_comb begin
        valid = !cfg_q[OFF_BIT] && LEGAL[cfg_q[NUM_W-1:0]];
        drive = (valid && cnt_q != '0) ? (LINES'(1) << cfg_q[NUM_W-1:0]) : '0;
    end

    // R10
    underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_down && !ev_up && cnt_q == '0) |=> (cnt_q == '0 && under_q));
    // R2
    masked_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q == ($past(wr_data) & KEEP)));
    // R7
    same_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_data & KEEP) == cfg_q)) |=> $stable(cfg_q));
    // R11
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && ev_up && !ev_down) |=> (cnt_q == CNT_MAX));
    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_up && !ev_down && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/irq_merge.sv
// Merges the per-slot line drives into one vector by OR.
// Assumes every slot drives zero or one line.
module irq_merge #(
    parameter int SLOTS = 8,
    parameter int LINES = 16
) (
    input  logic [SLOTS-1:0][LINES-1:0] drv,
    output logic [LINES-1:0]            merged
);
    // OR all slot drives together.
    always_comb begin
        merged = '0;
        for (int s = 0; s < SLOTS; s++) merged = merged | drv[s];
    end
endmodule

// File: rtl/irq_steer.sv
// Top of the interrupt pin router: eight routing slots, a read mux and the line merge.
// Assumes a single register port; reads are combinational on the pin index.
module irq_steer
    import irq_steer_pkg::*;
#(
    parameter int           N_PINS     = 8,
    parameter int           CNT_W      = 4,
    parameter logic [15:0]  LEGAL_MASK = 16'hDEF8,
    localparam int          SEL_W      = $clog2(N_PINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [N_PINS-1:0] src_up,
    input  logic [N_PINS-1:0] src_down,
    output logic [LINES-1:0]  irq_out,
    output logic              ovf_err
);
    logic [N_PINS-1:0][CFG_W-1:0] cfg_all;
    logic [N_PINS-1:0][LINES-1:0] drv_all;
    logic [N_PINS-1:0]            under_all;

    for (genvar i = 0; i < N_PINS; i++) begin : g_slot
        irq_slot #(.CNT_W(CNT_W), .LEGAL(LEGAL_MASK)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && cfg_sel == SEL_W'(i)),
            .wr_data (cfg_wdata),
            .ev_up   (src_up[i]),
            .ev_down (src_down[i]),
            .cfg_q   (cfg_all[i]),
            .drive   (drv_all[i]),
            .under_q (under_all[i])
        );
    end

    irq_merge #(.SLOTS(N_PINS), .LINES(LINES)) u_merge (
        .drv    (drv_all),
        .merged (irq_out)
    );

    // Present the selected pin's register and the combined underflow flag.
    always_comb begin
        cfg_rdata = cfg_all[cfg_sel];
        ovf_err   = |under_all;
    end

    // R3
    legal_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~LEGAL_MASK) == '0);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0 && !ovf_err));
endmodule

// File: tb/sim_irq_steer.sv
// Self-checking bench: exhaustive write sweep per pin, directed count cases, random mix.
module sim_irq_steer;
    localparam logic [15:0] LEGAL = 16'hDEF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [7:0]  src_up = '0, src_down = '0;
    logic [15:0] irq_out;
    logic        ovf_err;

    int total = 0, fails = 0;
    logic [7:0] mreg [8];
    int         mcnt [8];
    logic       merr;

    always #5 clk = ~clk;

    irq_steer u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_up(src_up),
        .src_down(src_down), .irq_out(irq_out), .ovf_err(ovf_err));

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_vec();
        logic [15:0] v = '0;
        for (int i = 0; i < 8; i++)
            if (mcnt[i] > 0 && !mreg[i][7] && LEGAL[mreg[i][3:0]])
                v[mreg[i][3:0]] = 1'b1;
        return v;
    endfunction

    // One cycle of stimulus, model update, then checks just after the edge.
    task automatic step(string tag, logic we, logic [2:0] sel, logic [7:0] wd,
                        logic [7:0] up, logic [7:0] dn);
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd; src_up = up; src_down = dn;
        @(posedge clk);
        merr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            int cu = (up[i] && mcnt[i] < 15) ? mcnt[i] + 1 : mcnt[i];
            if (dn[i] && cu == 0) merr = 1'b1;
            mcnt[i] = (dn[i] && cu != 0) ? cu - 1 : cu;
            if (we && sel == 3'(i)) mreg[i] = wd & 8'h8F;
        end
        #1;
        check(tag, irq_out, model_vec());
        check("R10", 16'(ovf_err), 16'(merr));
        check("R2", 16'(cfg_rdata), 16'(mreg[sel]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin mreg[i] = 8'h80; mcnt[i] = 0; end
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", irq_out, 16'h0);
        check("R1", 16'(ovf_err), 16'h0);
        for (int i = 0; i < 8; i++) begin
            cfg_sel = 3'(i); #1;
            check("R1", 16'(cfg_rdata), 16'h80);
        end
        @(negedge clk); rst_n = 1'b1;

        // Exhaustive write sweep per pin while active: R2 R3 R4 R6 R7
        for (int p = 0; p < 8; p++) begin
            step("R5", 1'b0, 3'(p), 8'h0, 8'(1 << p), 8'h0);
            for (int v = 0; v < 256; v++) begin
                logic [7:0] m = 8'(v) & 8'h8F;
                string tg = (m == mreg[p]) ? "R7" :
                            (!m[7] && !LEGAL[m[3:0]]) ? "R4" : "R6";
                step(tg, 1'b1, 3'(p), 8'(v), 8'h0, 8'h0);
            end
            step("R3", 1'b1, 3'(p), 8'h05, 8'h0, 8'h0);
            step("R7", 1'b1, 3'(p), 8'h75, 8'h0, 8'h0);
            step("R5", 1'b0, 3'(p), 8'h0, 8'h0, 8'(1 << p));
        end

        // R8: two pins share line 9
        step("R8", 1'b1, 3'd0, 8'h09, 8'h0, 8'h0);
        step("R8", 1'b1, 3'd1, 8'h09, 8'h03, 8'h0);
        step("R8", 1'b0, 3'd0, 8'h0, 8'h0, 8'h01);
        step("R8", 1'b0, 3'd0, 8'h0, 8'h0, 8'h02);

        // R5: three sources stacked on pin 2
        step("R5", 1'b1, 3'd2, 8'h0B, 8'h0, 8'h0);
        for (int k = 0; k < 3; k++) step("R5", 1'b0, 3'd2, 8'h0, 8'h04, 8'h0);
        for (int k = 0; k < 3; k++) step("R5", 1'b0, 3'd2, 8'h0, 8'h0, 8'h04);

        // R9: write and raise in the same cycle on pin 3
        step("R9", 1'b1, 3'd3, 8'h0E, 8'h08, 8'h0);
        step("R9", 1'b1, 3'd3, 8'h0F, 8'h0, 8'h08);
        step("R9", 1'b1, 3'd3, 8'h0C, 8'h08, 8'h08);

        // R10: lower at zero ignored, count stays zero
        step("R10", 1'b0, 3'd4, 8'h0, 8'h0, 8'h10);
        step("R10", 1'b1, 3'd4, 8'h04, 8'h10, 8'h0);
        step("R10", 1'b0, 3'd4, 8'h0, 8'h0, 8'h10);
        step("R10", 1'b0, 3'd4, 8'h0, 8'h0, 8'h0);

        // R11: saturate pin 5, then drain
        step("R11", 1'b1, 3'd5, 8'h06, 8'h0, 8'h0);
        for (int k = 0; k < 18; k++) step("R11", 1'b0, 3'd5, 8'h0, 8'h20, 8'h0);
        for (int k = 0; k < 16; k++) step("R11", 1'b0, 3'd5, 8'h0, 8'h0, 8'h20);

        // Mixed pseudo-random traffic: R8 R9 R6
        begin
            logic [15:0] lf = 16'hACE1;
            for (int k = 0; k < 3000; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step("R8", lf[3:0] == 4'h0, lf[6:4], lf[15:8],
                     lf[7:0] & lf[15:8], lf[15:8] & ~lf[7:0] & {lf[3:0], lf[7:4]});
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule